// File: doc/BRIEF.md
# Mixed-width simple dual-port RAM

This block is a 576-bit on-chip memory with one write port and one read port. Both ports run on one clock and work independently in the same cycle. Each port is given its own word shape by parameter. The plain shapes are 1, 2, 4, 8 and 16 bits wide and together cover 512 bits. The parity shapes are 9 and 18 bits wide and cover all 576 bits.

Both ports see the storage as one linear bit string. A word of width W at address A occupies bits A*W through A*W+W-1. As a result, a narrow word at address A sits inside the wide word at address A/ratio, in slot A mod ratio, with slot 0 in the least significant bits. Data written at one width can therefore be read back at any other legal width.

The ports are plain enable/address/data pins. A memory port has no flow to stall, so there is no back-pressure: a write enable always commits, and a read enable always loads the output register.

Top module: `mwram_sdp`

## Requirements
- R1: With `wr_en` high at a rising edge, bits [A*WR_W +: WR_W] of the linear store take `wr_data` (A = `wr_addr`), and every other bit keeps its value.
- R2: With `wr_en` low, no bit of the store changes, whatever `wr_addr` and `wr_data` carry.
- R3: With `rd_en` high at a rising edge, `rd_data` shows bits [A*RD_W +: RD_W] of the store (A = `rd_addr`) after that edge, which is one cycle of latency.
- R4: With `rd_en` low, `rd_data` holds its previous value, even while writes change the addressed bits.
- R5: When a read and a write touch overlapping bits at the same edge, the read returns the contents from before that write.
- R6: A 1-bit write at address A appears in the 16-bit word at address A/16, at bit position A mod 16.
- R7: A 16-bit word written at address B is returned by 4-bit reads at addresses 4B to 4B+3, least significant nibble first.
- R8: The 9-bit and 18-bit shapes span 576 bits. A 9-bit word at address A is bit field [9*(A mod 2) +: 9] of the 18-bit word A/2, up to 9-bit address 63 and 18-bit address 31.
- R9: While `rst` is high at a rising edge, `rd_data` is cleared to zero. The store itself is not cleared.
- R10: Each width must be one of 1, 2, 4, 8, 16, 9 or 18. A parity width (9 or 18) may be paired only with a parity width. Any other setting stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the read register, active high |
| wr_en | input | 1 | Write enable |
| wr_addr | input | log2(span/WR_W) | Write word address |
| wr_data | input | WR_W | Write data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | log2(span/RD_W) | Read word address |
| rd_data | output | RD_W | Registered read data |

## Verification
The assertions assume that `wr_en`, `rd_en` and both addresses are known (never X) at each rising edge once reset is released. They also assume that the store bits checked for stability have been written at least once, or are known. To stay within these assumptions, the stimulus changes every input only on falling edges and holds the enables low during reset. It also fills each instance's whole store before any read whose value is compared. Each address that is driven lies inside its shape's power-of-two depth.

// File: rtl/mwram_pkg.sv
package mwram_pkg;
  localparam int PLAIN_SPAN = 512;
  localparam int FULL_SPAN  = 576;
  localparam int BASE_W     = $clog2(FULL_SPAN);

  function automatic bit is_parity(int w);
    return (w == 9) || (w == 18);
  endfunction

  function automatic bit is_plain(int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
  endfunction

  function automatic bit pair_ok(int a, int b);
    return (is_plain(a) && is_plain(b)) || (is_parity(a) && is_parity(b));
  endfunction

  function automatic int span_of(int w);
    return is_parity(w) ? FULL_SPAN : PLAIN_SPAN;
  endfunction

  function automatic int depth_of(int w);
    return (w > 0) ? span_of(w) / w : 1;
  endfunction

  function automatic int addr_bits(int w);
    return (depth_of(w) > 1) ? $clog2(depth_of(w)) : 1;
  endfunction
endpackage

// File: rtl/mwram_addr_map.sv
module mwram_addr_map
  import mwram_pkg::*;
#(
  parameter int W  = 1,
  parameter int AW = 9
) (
  input  logic [AW-1:0]     addr,
  output logic [BASE_W-1:0] base
);
  localparam bit POW2 = (W & (W - 1)) == 0;
  localparam int SHIFT = (W > 1) ? $clog2(W) : 0;

  generate
    if (POW2) begin : g_shift
      assign base = BASE_W'(addr) << SHIFT;
    end else begin : g_mult
      assign base = BASE_W'(addr) * BASE_W'(W);
    end
  endgenerate
endmodule

// File: rtl/mwram_array.sv
module mwram_array
  import mwram_pkg::*;
#(
  parameter int WR_W = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [BASE_W-1:0]    wbase,
  input  logic [WR_W-1:0]      wdata,
  output logic [FULL_SPAN-1:0] bits_q
);
  always_ff @(posedge clk) begin
    if (we) bits_q[wbase +: WR_W] <= wdata;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    we |=> bits_q[$past(wbase) +: WR_W] == $past(wdata)); // R1

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(bits_q)); // R2
endmodule

// File: rtl/mwram_rd_port.sv
module mwram_rd_port
  import mwram_pkg::*;
#(
  parameter int RD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 re,
  input  logic [BASE_W-1:0]    rbase,
  input  logic [FULL_SPAN-1:0] bits,
  output logic [RD_W-1:0]      rdata
);
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= bits[rbase +: RD_W];
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata)); // R4
endmodule

// File: rtl/mwram_sdp.sv
module mwram_sdp
  import mwram_pkg::*;
#(
  parameter int WR_W = 1,
  parameter int RD_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [addr_bits(WR_W)-1:0]    wr_addr,
  input  logic [WR_W-1:0]               wr_data,
  input  logic                          rd_en,
  input  logic [addr_bits(RD_W)-1:0]    rd_addr,
  output logic [RD_W-1:0]               rd_data
);
  localparam int WA_W = addr_bits(WR_W);
  localparam int RA_W = addr_bits(RD_W);

  // R10: legal shapes only, parity paired with parity
  generate
    if (!pair_ok(WR_W, RD_W)) begin : g_bad_shape
      $error("mwram_sdp: illegal width pair");
    end
  endgenerate

  logic [BASE_W-1:0]    wbase, rbase;
  logic [FULL_SPAN-1:0] store;

  mwram_addr_map #(.W(WR_W), .AW(WA_W)) u_wmap (.addr(wr_addr), .base(wbase));
  mwram_addr_map #(.W(RD_W), .AW(RA_W)) u_rmap (.addr(rd_addr), .base(rbase));

  mwram_array #(.WR_W(WR_W)) u_array (
    .clk(clk), .rst(rst), .we(wr_en), .wbase(wbase), .wdata(wr_data), .bits_q(store)
  );

  mwram_rd_port #(.RD_W(RD_W)) u_rd (
    .clk(clk), .rst(rst), .re(rd_en), .rbase(rbase), .bits(store), .rdata(rd_data)
  );

  // Read sees the pre-write store: old data on overlap
  AST_RD_FROM_ARRAY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data == $past(store[rbase +: RD_W])); // R3 R5
endmodule

// File: tb/mwram_sdp_bench.sv
module mwram_sdp_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // instance A: 1-bit write, 16-bit read
  logic       weA = 0, reA = 0;
  logic [8:0] waA = 0;
  logic       wdA = 0;
  logic [4:0] raA = 0;
  logic [15:0] rdA;
  // instance B: 16-bit write, 4-bit read
  logic       weB = 0, reB = 0;
  logic [4:0] waB = 0;
  logic [15:0] wdB = 0;
  logic [6:0] raB = 0;
  logic [3:0] rdB;
  // instance C: 9-bit write, 18-bit read
  logic       weC = 0, reC = 0;
  logic [5:0] waC = 0;
  logic [8:0] wdC = 0;
  logic [4:0] raC = 0;
  logic [17:0] rdC;

  logic [575:0] refA = '0, refB = '0, refC = '0;

  mwram_sdp #(.WR_W(1), .RD_W(16)) u_mwram_sdp (
    .clk(clk), .rst(rst), .wr_en(weA), .wr_addr(waA), .wr_data(wdA),
    .rd_en(reA), .rd_addr(raA), .rd_data(rdA));
  mwram_sdp #(.WR_W(16), .RD_W(4)) u_mwram_sdp_w16r4 (
    .clk(clk), .rst(rst), .wr_en(weB), .wr_addr(waB), .wr_data(wdB),
    .rd_en(reB), .rd_addr(raB), .rd_data(rdB));
  mwram_sdp #(.WR_W(9), .RD_W(18)) u_mwram_sdp_w9r18 (
    .clk(clk), .rst(rst), .wr_en(weC), .wr_addr(waC), .wr_data(wdC),
    .rd_en(reC), .rd_addr(raC), .rd_data(rdC));

  // {kind[1:0], addr[9:0], data[17:0]}; kind 1 = write, 2 = read and compare
  localparam logic [29:0] VEC [14] = '{
    {2'd1, 10'd0,   18'd1}, {2'd1, 10'd3,   18'd1}, {2'd1, 10'd15,  18'd1},
    {2'd2, 10'd0,   18'd0}, {2'd1, 10'd16,  18'd1}, {2'd1, 10'd31,  18'd1},
    {2'd2, 10'd1,   18'd0}, {2'd1, 10'd511, 18'd1}, {2'd2, 10'd31,  18'd0},
    {2'd1, 10'd0,   18'd0}, {2'd2, 10'd0,   18'd0}, {2'd1, 10'd500, 18'd1},
    {2'd2, 10'd31,  18'd0}, {2'd2, 10'd2,   18'd0}
  };

  task automatic chk(string req, logic [17:0] got, logic [17:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr_a(int a, logic d);
    weA = 1; waA = 9'(a); wdA = d;
    @(negedge clk);
    weA = 0;
    refA[a] = d;
  endtask

  task automatic rd_a(int a, string req);
    reA = 1; raA = 5'(a);
    @(negedge clk);
    reA = 0;
    chk(req, {2'b0, rdA}, {2'b0, refA[a*16 +: 16]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 A", {2'b0, rdA}, 18'd0);
    chk("R9 B", {14'b0, rdB}, 18'd0);
    chk("R9 C", rdC, 18'd0);
    rst = 0;
    @(negedge clk);

    for (int i = 0; i < 512; i++) wr_a(i, 1'b0);

    // R1 R6 table walk
    for (int k = 0; k < 14; k++) begin
      if (VEC[k][29:28] == 2'd1) wr_a(int'(VEC[k][27:18]), VEC[k][0]);
      else rd_a(int'(VEC[k][27:18]), "R6 table");
    end

    // R4: hold while a write changes the addressed word
    rd_a(0, "R3 read word0");
    begin
      logic [15:0] held;
      held = rdA;
      wr_a(1, 1'b1);
      @(negedge clk);
      chk("R4 hold", {2'b0, rdA}, {2'b0, held});
    end
    rd_a(0, "R1 new bit");

    // R2: disabled write with live address/data
    waA = 9'd2; wdA = 1'b1; weA = 0;
    @(negedge clk);
    rd_a(0, "R2 no write");

    // R5: overlap in one edge
    begin
      logic [15:0] old;
      old = refA[16 +: 16];
      weA = 1; waA = 9'd20; wdA = 1'b1; reA = 1; raA = 5'd1;
      @(negedge clk);
      weA = 0; reA = 0;
      refA[20] = 1'b1;
      chk("R5 old data", {2'b0, rdA}, {2'b0, old});
    end
    rd_a(1, "R5 new data");

    // R7: wide write, narrow read
    for (int i = 0; i < 32; i++) begin
      logic [15:0] d;
      d = 16'(i * 16'h1357) ^ 16'hA5C3;
      weB = 1; waB = 5'(i); wdB = d;
      @(negedge clk);
      refB[i*16 +: 16] = d;
    end
    weB = 0;
    for (int i = 0; i < 128; i++) begin
      reB = 1; raB = 7'(i);
      @(negedge clk);
      reB = 0;
      chk("R7 nibble", {14'b0, rdB}, {14'b0, refB[i*4 +: 4]});
    end

    // R8: parity shapes over 576 bits
    for (int i = 0; i < 64; i++) begin
      logic [8:0] d;
      d = 9'(i * 37 + 5);
      weC = 1; waC = 6'(i); wdC = d;
      @(negedge clk);
      refC[i*9 +: 9] = d;
    end
    weC = 0;
    for (int i = 0; i < 32; i++) begin
      reC = 1; raC = 5'(i);
      @(negedge clk);
      reC = 0;
      chk("R8 pair", rdC, refC[i*18 +: 18]);
    end
    chk("R8 top word", rdC, {9'(63 * 37 + 5), 9'(62 * 37 + 5)});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule